// File: doc/BRIEF.md
# Legacy I/O Request Router

This block decides where a processor I/O read or write goes. It receives the request address, byte enables and direction. It returns a single target code that names either one of several PCI Express downstream ports or the default legacy link. It also raises a flag when the request touches the configuration-protocol data/address doubleword pair, so that a neighbouring configuration engine can take the cycle. Each downstream port has its own software-programmed settings. These are an I/O decode enable, an alias-filter enable, and an inclusive base/limit window. The settings arrive as plain inputs from the register file that owns them.

The rules are checked in a fixed order. The first rule handles an overflowing address: bit 16 set folds the request to address zero and sends it to the legacy link. The next rule handles the configuration-protocol addresses. After that come the alias filter, the plain window match and the default. Matching uses address bits 15:3 only, so the block only ever receives bits 16:3. Byte-level detail is carried in the byte enables. The result is registered and offered through a valid/ready pair. A stalled result is held, and a new request can be accepted in the same cycle that the old result is taken.

Top module: `io_route_decoder`

## Requirements
- R1: After reset `res_valid` is 0 and `req_ready` is 1. While every `port_io_en` bit is 0, every request returns target code 0 (the legacy link).
- R2: Only address bits 15:3 take part in matching. `req_addr` carries bits 16:3. Base and limit are given as bits 15:3. All bytes of one 8-byte group route the same way.
- R3: A request with `req_addr[16]` set returns target 0 with `res_cfg` 0, even when a port window covers address zero.
- R4: A request whose bits 15:3 equal 0CF8h>>3 (bytes 0CF8h–0CFFh, covering 0CF8h and 0CFCh), with bit 16 clear, returns `res_cfg` 1 and target 0, whatever the port windows are.
- R5: If a port has decode and alias enable set, and the address lies in its window with bits 9:8 not both zero (offset 100h–3FFh in its 1 KB block), the target is 0.
- R6: A port p with decode enable set and base ≤ address ≤ limit (both inclusive) gets target code p+1 (codes: 0 legacy, 1..4 = port 0..3).
- R7: An alias hit on any port takes precedence over a plain window hit on any other port.
- R8: When several port windows match and no alias hit exists, the lowest-numbered port wins.
- R9: A port whose limit is below its base never matches.
- R10: An address that matches no rule returns target 0.
- R11: A result appears on `res_valid` at the first clock edge after its request is accepted. It stays unchanged while `res_ready` is 0. `req_ready` is 1 whenever no result is held or the held one is being taken.
- R12: `res_nodata` is 1 exactly when `res_cfg` is 1 and all byte enables of the request were 0 (a zero-length configuration cycle that completes with no data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 14 | I/O address bits 16:3 |
| req_be | input | 8 | Byte enables within the 8-byte group |
| req_write | input | 1 | 1 = write, 0 = read |
| port_io_en | input | 4 | Per-port I/O decode enable |
| port_alias_en | input | 4 | Per-port alias-filter enable |
| port_base | input | 52 | Per-port window base, bits 15:3, port p at [13p+12:13p] |
| port_limit | input | 52 | Per-port window limit, bits 15:3, same packing |
| res_valid | output | 1 | Routing result present |
| res_ready | input | 1 | Consumer takes the result |
| res_target | output | 3 | 0 legacy link, p+1 port p |
| res_cfg | output | 1 | Configuration-protocol address |
| res_nodata | output | 1 | Zero-length configuration cycle |
| res_write | output | 1 | Direction of the routed request |

## Verification
The hardest case to reach from the ports is a request that lies in two windows at once, where one port wants to keep it through a plain range hit and another port with alias enable wants to pull it back to the legacy link. The rule order and the lowest-port choice only show up there. The stimulus programs overlapping windows with different alias settings, then probes addresses on both sides of the 100h and 400h block offsets. A second hard point is a result held under back-pressure while the next request waits. A pseudo-random `res_ready` pattern during a long random burst creates this, and the per-cycle model comparison confirms that the held values do not change.

// File: rtl/io_route_pkg.sv
package io_route_pkg;

    // Byte address of the configuration-protocol address/data doubleword pair
    localparam int unsigned CFG_PAIR_ADDR = 32'h0000_0CF8;

    // Which rule decided a request, in priority order
    typedef enum logic [2:0] {
        RULE_DEFAULT = 3'd0,
        RULE_FOLD    = 3'd1,
        RULE_CFG     = 3'd2,
        RULE_ALIAS   = 3'd3,
        RULE_RANGE   = 3'd4
    } rule_e;

endpackage

// File: rtl/io_port_window.sv
module io_port_window #(
    parameter int unsigned QW        = 13,
    parameter int unsigned LSB       = 3,
    parameter int unsigned ALIAS_MSB = 9,
    parameter int unsigned ALIAS_LSB = 8
) (
    input  logic [QW-1:0] qaddr,
    input  logic [QW-1:0] base,
    input  logic [QW-1:0] limit,
    input  logic          io_en,
    input  logic          alias_en,
    output logic          range_hit,
    output logic          alias_hit
);

    localparam int unsigned AM = ALIAS_MSB - LSB;
    localparam int unsigned AL = ALIAS_LSB - LSB;

    logic above_base;
    logic below_limit;
    logic upper_block;

    always_comb begin
        above_base  = (qaddr >= base);
        below_limit = (qaddr <= limit);
        // inverted window (limit < base) can never satisfy both compares
        range_hit   = io_en && above_base && below_limit;
        // offset 100h..3FFh in each 1 KB block
        upper_block = |qaddr[AM:AL];
        alias_hit   = range_hit && alias_en && upper_block;
    end

endmodule

// File: rtl/io_route_arbiter.sv
module io_route_arbiter
    import io_route_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned TGT_W     = 3
) (
    input  logic [NUM_PORTS-1:0] range_hit,
    input  logic [NUM_PORTS-1:0] alias_hit,
    input  logic                 fold,
    input  logic                 cfg_hit,
    output logic [TGT_W-1:0]     target,
    output rule_e                rule
);

    logic             found;
    logic [TGT_W-1:0] port_code;

    always_comb begin
        found     = 1'b0;
        port_code = '0;
        // walk downward so the lowest matching port is written last
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (range_hit[p]) begin
                found     = 1'b1;
                port_code = TGT_W'(p + 1);
            end
        end

        if (fold)
            rule = RULE_FOLD;
        else if (cfg_hit)
            rule = RULE_CFG;
        else if (|alias_hit)
            rule = RULE_ALIAS;
        else if (found)
            rule = RULE_RANGE;
        else
            rule = RULE_DEFAULT;

        target = (rule == RULE_RANGE) ? port_code : '0;
    end

endmodule

// File: rtl/io_route_decoder.sv
module io_route_decoder
    import io_route_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LSB       = 3,
    parameter int unsigned BE_W      = 8,
    parameter int unsigned ALIAS_MSB = 9,
    parameter int unsigned ALIAS_LSB = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [ADDR_W:LSB]                    req_addr,
    input  logic [BE_W-1:0]                      req_be,
    input  logic                                 req_write,
    input  logic [NUM_PORTS-1:0]                 port_io_en,
    input  logic [NUM_PORTS-1:0]                 port_alias_en,
    input  logic [NUM_PORTS*(ADDR_W-LSB)-1:0]    port_base,
    input  logic [NUM_PORTS*(ADDR_W-LSB)-1:0]    port_limit,
    output logic                                 res_valid,
    input  logic                                 res_ready,
    output logic [$clog2(NUM_PORTS+1)-1:0]       res_target,
    output logic                                 res_cfg,
    output logic                                 res_nodata,
    output logic                                 res_write
);

    localparam int unsigned QW    = ADDR_W - LSB;
    localparam int unsigned TGT_W = $clog2(NUM_PORTS + 1);
    localparam logic [QW-1:0] CFG_QADDR = QW'(CFG_PAIR_ADDR >> LSB);

    typedef struct packed {
        logic             valid;
        logic [TGT_W-1:0] target;
        logic             cfg;
        logic             nodata;
        logic             write;
    } res_t;

    res_t st_d, st_q;

    logic                 fold;
    logic [QW-1:0]        eff_q;
    logic                 cfg_hit;
    logic [NUM_PORTS-1:0] range_hit;
    logic [NUM_PORTS-1:0] alias_hit;
    logic [TGT_W-1:0]     arb_target;
    rule_e                arb_rule;
    logic                 accept;

    // overflow past 64 KB folds to address zero
    always_comb begin
        fold    = req_addr[ADDR_W];
        eff_q   = fold ? '0 : req_addr[ADDR_W-1:LSB];
        cfg_hit = !fold && (eff_q == CFG_QADDR);
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_win
        io_port_window #(
            .QW        (QW),
            .LSB       (LSB),
            .ALIAS_MSB (ALIAS_MSB),
            .ALIAS_LSB (ALIAS_LSB)
        ) u_win (
            .qaddr     (eff_q),
            .base      (port_base[g*QW +: QW]),
            .limit     (port_limit[g*QW +: QW]),
            .io_en     (port_io_en[g]),
            .alias_en  (port_alias_en[g]),
            .range_hit (range_hit[g]),
            .alias_hit (alias_hit[g])
        );
    end

    io_route_arbiter #(
        .NUM_PORTS (NUM_PORTS),
        .TGT_W     (TGT_W)
    ) u_arb (
        .range_hit (range_hit),
        .alias_hit (alias_hit),
        .fold      (fold),
        .cfg_hit   (cfg_hit),
        .target    (arb_target),
        .rule      (arb_rule)
    );

    assign req_ready = !st_q.valid || res_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && res_ready)
            st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid  = 1'b1;
            st_d.target = arb_target;
            st_d.cfg    = (arb_rule == RULE_CFG);
            st_d.nodata = (arb_rule == RULE_CFG) && (req_be == '0);
            st_d.write  = req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_valid  = st_q.valid;
    assign res_target = st_q.target;
    assign res_cfg    = st_q.cfg;
    assign res_nodata = st_q.nodata;
    assign res_write  = st_q.write;

    // R1: reset leaves no result pending
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R1: with every port disabled the legacy link is chosen
    p_ports_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && port_io_en == '0) |=> (res_valid && res_target == '0));

    // R3: overflow requests go to the legacy link without the config flag
    p_fold_legacy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_addr[ADDR_W]) |=> (res_target == '0 && !res_cfg));

    // R4: configuration-pair addresses are flagged and not range-routed
    p_cfg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_addr[ADDR_W] && req_addr[ADDR_W-1:LSB] == CFG_QADDR)
        |=> (res_cfg && res_target == '0));

    // R6: target code stays within legacy plus the port count
    p_target_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (32'(res_target) <= NUM_PORTS));

    // R11: result appears one edge after acceptance
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid);

    // R11: a stalled result holds its value
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
        (res_valid && $stable(res_target) && $stable(res_cfg) &&
         $stable(res_nodata) && $stable(res_write)));

    // R12: no-data marking only on configuration-pair cycles
    p_nodata_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_nodata) |-> res_cfg);

endmodule

// File: tb/io_route_decoder_test.sv
module io_route_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:3] req_addr = '0;
    logic [7:0]  req_be = '0;
    logic        req_write = 1'b0;
    logic [3:0]  port_io_en;
    logic [3:0]  port_alias_en;
    logic [51:0] port_base;
    logic [51:0] port_limit;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [2:0]  res_target;
    logic        res_cfg;
    logic        res_nodata;
    logic        res_write;

    bit          en  [4];
    bit          aen [4];
    logic [15:0] base_b [4];
    logic [15:0] lim_b  [4];

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";
    bit    stall_mode = 1'b0;

    int    tq[$];
    bit    cq[$];
    bit    nq[$];
    bit    wq[$];
    string gq[$];

    always #2.5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < 4; p++) begin
            port_io_en[p]          = en[p];
            port_alias_en[p]       = aen[p];
            port_base[p*13 +: 13]  = base_b[p][15:3];
            port_limit[p*13 +: 13] = lim_b[p][15:3];
        end
    end

    io_route_decoder uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_be        (req_be),
        .req_write     (req_write),
        .port_io_en    (port_io_en),
        .port_alias_en (port_alias_en),
        .port_base     (port_base),
        .port_limit    (port_limit),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_target    (res_target),
        .res_cfg       (res_cfg),
        .res_nodata    (res_nodata),
        .res_write     (res_write)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference: ordered rule list
    task automatic model(input logic [16:3] a, input logic [7:0] be,
                         output int tgt, output bit cfg, output bit nd);
        int  q;
        int  first;
        bit  any_alias;
        q = int'(a[15:3]);
        tgt = 0; cfg = 0; nd = 0;
        if (a[16]) return;
        if (q == (32'h0CF8 / 8)) begin
            cfg = 1;
            nd  = (be == 8'h00);
            return;
        end
        any_alias = 0;
        first = -1;
        for (int p = 0; p < 4; p++) begin
            if (en[p] && q >= int'(base_b[p][15:3]) && q <= int'(lim_b[p][15:3])) begin
                if (aen[p] && ((q * 8) % 1024) >= 256) any_alias = 1;
                if (first < 0) first = p;
            end
        end
        if (any_alias) tgt = 0;
        else if (first >= 0) tgt = first + 1;
    endtask

    // monitor: compare on every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (res_valid) begin
                if (tq.size() == 0) begin
                    chk(1'b0, "R11", "result without request", 1, 0);
                end else begin
                    chk(int'(res_target) == tq[0], gq[0], "target", int'(res_target), tq[0]);
                    chk(res_cfg == cq[0], gq[0], "cfg flag", int'(res_cfg), int'(cq[0]));
                    chk(res_nodata == nq[0], gq[0], "nodata", int'(res_nodata), int'(nq[0]));
                    chk(res_write == wq[0], gq[0], "write", int'(res_write), int'(wq[0]));
                    if (res_ready) begin
                        void'(tq.pop_front()); void'(cq.pop_front());
                        void'(nq.pop_front()); void'(wq.pop_front());
                        void'(gq.pop_front());
                    end
                end
            end
            if (req_valid && req_ready) begin
                int t; bit c; bit n;
                model(req_addr, req_be, t, c, n);
                tq.push_back(t); cq.push_back(c); nq.push_back(n);
                wq.push_back(req_write); gq.push_back(cur_tag);
            end
        end
    end

    always @(negedge clk) begin
        if (stall_mode) res_ready <= ($urandom % 3) != 0;
        else            res_ready <= 1'b1;
    end

    task automatic send(input logic [16:0] addr, input logic [7:0] be,
                        input bit wr, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        req_valid = 1'b1;
        req_addr  = addr[16:3];
        req_be    = be;
        req_write = wr;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        idle();
        while (tq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_port(input int p, input bit e, input bit a,
                            input logic [15:0] b, input logic [15:0] l);
        en[p] = e; aen[p] = a; base_b[p] = b; lim_b[p] = l;
    endtask

    task automatic clear_ports();
        for (int p = 0; p < 4; p++) set_port(p, 0, 0, 16'h0000, 16'h0000);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        clear_ports();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

        // R1 / R10: nothing enabled
        send(17'h01000, 8'hFF, 0, "R1");
        send(17'h003F8, 8'h0F, 1, "R1");
        send(17'h0FFF8, 8'hF0, 0, "R10");
        drain();

        // R11: one-edge latency
        send(17'h02000, 8'hFF, 1, "R11");
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        chk(res_valid == 1'b1, "R11", "valid one edge after accept", int'(res_valid), 1);
        drain();

        // R6 / R10: inclusive bounds of a single window
        set_port(0, 1, 0, 16'h1000, 16'h1FF8);
        send(17'h01000, 8'hFF, 0, "R6");
        send(17'h01FF8, 8'hFF, 0, "R6");
        send(17'h00FF8, 8'hFF, 0, "R10");
        send(17'h02000, 8'hFF, 0, "R10");

        // R2: only bits 15:3 matter
        set_port(1, 1, 0, 16'h3000, 16'h3000);
        send(17'h03004, 8'hF0, 0, "R2");
        send(17'h03007, 8'h80, 1, "R2");
        send(17'h03008, 8'h01, 0, "R2");

        // R9: inverted window
        set_port(2, 1, 0, 16'h5000, 16'h4000);
        send(17'h04800, 8'hFF, 0, "R9");
        send(17'h05000, 8'hFF, 0, "R9");
        drain();

        // R8: lowest port wins
        set_port(3, 1, 0, 16'h1000, 16'h1FF8);
        send(17'h01800, 8'hFF, 0, "R8");
        drain();
        en[0] = 0;
        send(17'h01800, 8'hFF, 0, "R8");
        drain();

        // R5: alias filter within a port window
        clear_ports();
        set_port(0, 1, 1, 16'h1000, 16'h1FF8);
        send(17'h01000, 8'hFF, 0, "R5");
        send(17'h010F8, 8'hFF, 0, "R5");
        send(17'h01100, 8'hFF, 0, "R5");
        send(17'h013F8, 8'hFF, 1, "R5");
        send(17'h01400, 8'hFF, 0, "R5");
        send(17'h01A00, 8'hFF, 0, "R5");
        drain();

        // R7: alias on one port beats a plain hit on another
        clear_ports();
        set_port(0, 1, 0, 16'h8000, 16'h8FF8);
        set_port(1, 1, 1, 16'h8000, 16'h8FF8);
        send(17'h08100, 8'hFF, 0, "R7");
        send(17'h08000, 8'hFF, 0, "R7");
        send(17'h08C00, 8'hFF, 0, "R7");
        drain();

        // R3: overflow folds to zero, legacy link
        clear_ports();
        set_port(0, 1, 0, 16'h0000, 16'hFFF8);
        send(17'h10000, 8'hFF, 0, "R3");
        send(17'h10CF8, 8'hFF, 1, "R3");
        send(17'h00000, 8'hFF, 0, "R3");

        // R4: configuration pair flagged
        send(17'h00CF8, 8'h0F, 1, "R4");
        send(17'h00CFC, 8'hF0, 0, "R4");
        send(17'h00CF0, 8'hFF, 0, "R4");
        send(17'h00D00, 8'hFF, 0, "R4");

        // R12: zero-length configuration cycle
        send(17'h00CF8, 8'h00, 0, "R12");
        send(17'h00CFC, 8'h0F, 0, "R12");
        send(17'h00000, 8'h00, 0, "R12");
        drain();

        // R11 / R7 / R8: random burst under back-pressure
        stall_mode = 1'b1;
        set_port(0, 1, 1, 16'h0400, 16'h0BF8);
        set_port(1, 1, 0, 16'h0800, 16'h13F8);
        set_port(2, 1, 1, 16'h0C00, 16'h0800);
        set_port(3, 1, 0, 16'h0000, 16'hFFF8);
        for (int i = 0; i < 120; i++) begin
            logic [16:0] a;
            a = 17'($urandom);
            if (i % 4 == 0) a[16] = 1'b0;
            if (i % 7 == 0) a = 17'h00CF8;
            if (i % 5 == 0) a = {5'b0, a[11:0]};
            send(a, 8'($urandom), bit'($urandom), "R11");
            if (i == 60) aen[1] = 1;
        end
        stall_mode = 1'b0;
        drain();

        finish_run();
    end

endmodule